// File: doc/BRIEF.md
# Floppy Controller Enhanced-Personality Register Bank

This block is the register file a floppy controller uses once software has moved it out of its legacy personality into the enhanced one. It sits on a byte-wide bus. The register index is the byte address shifted right by nine bits, which gives four index bits. Index values 0 to 7 are write registers and 8 to 15 are read registers. The block holds a phase byte and a mode byte, and software changes the mode byte only through two write ports: one clears bits and the other sets bits. It also holds a sixteen-entry parameter store. Reads and writes of that store walk a single shared pointer that wraps around.

A three-state personality machine decides when the block answers the bus. `ST_LEGACY` is the state after reset. In it the block ignores every bus access. It moves to `ST_ENHANCED` when the legacy front end raises `enter_enhanced`, and that transition sets mode bit 6. In `ST_ENHANCED` all registers are live. A clear-bits write that leaves mode bit 6 at zero moves the machine to `ST_RELEASE`. That state lasts exactly one cycle and drives a pulse that tells the legacy side to zero its latches. From `ST_RELEASE` the machine always returns to `ST_LEGACY`.

The block does not implement data, mark and CRC transfer, the setup register or any drive mechanics. Writes to those registers are accepted with no effect, and reads of them return zero.

Top module: `flp_enh_regbank`

## Requirements
- R1: After reset the machine is in `ST_LEGACY`: `enhanced_active` is 0, `legacy_latch_clr` is 0, `mode_out` is 0x00, and the phase byte is 0x00. A phase read after the first entry into enhanced mode returns 0x00.
- R2: While `enhanced_active` is 0, bus writes change no register and `bus_rdata` is 0x00.
- R3: In `ST_LEGACY`, `enter_enhanced` high at a clock edge makes `enhanced_active` 1 from that edge and sets `mode_out` bit 6. The other mode bits keep their values. While `enhanced_active` is 1, `mode_out` bit 6 is 1.
- R4: The register index is `bus_addr[12:9]` and the low nine address bits are ignored. A write to index 4 stores the phase byte, and a read of index 12 returns it unchanged.
- R5: A write to index 7 ORs `bus_wdata` into the mode byte.
- R6: A write to index 6 clears every mode bit that is 1 in `bus_wdata` and returns the parameter pointer to entry 0.
- R7: If a write to index 6 leaves mode bit 6 at 0, then from that clock edge `enhanced_active` is 0 and `legacy_latch_clr` is 1 for exactly one cycle, after which the machine is in `ST_LEGACY`.
- R8: A write to index 3 stores into the parameter entry at the pointer. A read of index 11 returns the entry at the pointer. Both accesses advance the one shared pointer, which wraps from 15 back to 0. The entries are not cleared by reset.
- R9: A read of index 15 returns 0x08 when the phase byte equals 0x77 and returns 0x00 otherwise.
- R10: A read of index 14 returns 0x40 while enhanced mode is active.
- R11: Writes to indices 0, 1, 2 and 5, and writes to indices 8 to 15, change no register. Reads of indices 8, 9, 10 and 13, and reads with an index from 0 to 7, return 0x00. None of these accesses moves the parameter pointer.
- R12: `bus_rdata` is 0x00 in every cycle with no read access (`bus_sel` low or `bus_we` high). During a read it is valid in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter_enhanced | input | 1 | Switch request from the legacy front end |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bits 12:9 give the register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during the access |
| enhanced_active | output | 1 | Machine is in `ST_ENHANCED` |
| legacy_latch_clr | output | 1 | One-cycle request to zero the legacy latches |
| mode_out | output | 8 | Current mode byte |

## Verification
The parameter store is filled with sixteen distinct values and then given a seventeenth write. Reading the store back from a cleared pointer shows whether the pointer wraps at sixteen and whether entry 0 was overwritten. Interleaved reads and writes show whether the read and write paths share one pointer. Addresses carry nonzero low bits, so a decoder that uses the wrong bits shows up as a wrong register. The phase byte is tried at 0x77 and at its neighbours 0x76 and 0x07, which distinguishes an exact compare from a partial one. The mode byte goes through set, partial clear, clear of bit 6, and re-entry, which checks the OR and AND-NOT updates and the exit pulse. Writes made while the block is in legacy mode are checked by reading the registers back after re-entry.

// File: rtl/flp_enh_pkg.sv
package flp_enh_pkg;

    typedef enum logic [1:0] {
        ST_LEGACY   = 2'd0,
        ST_ENHANCED = 2'd1,
        ST_RELEASE  = 2'd2
    } pers_state_e;

    // Write slots (index 0..7)
    localparam int unsigned WS_PARAM = 3;
    localparam int unsigned WS_PHASE = 4;
    localparam int unsigned WS_CLR   = 6;
    localparam int unsigned WS_SET   = 7;

    // Read slots, relative to index 8
    localparam int unsigned RS_PARAM  = 3;
    localparam int unsigned RS_PHASE  = 4;
    localparam int unsigned RS_STATUS = 6;
    localparam int unsigned RS_HSHAKE = 7;

    localparam int unsigned ACT_BIT         = 6;
    localparam int unsigned NO_DRIVE_PHASE  = 8'h77;
    localparam int unsigned SENSE_VALUE     = 8'h08;

endpackage

// File: rtl/flp_enh_decode.sv
module flp_enh_decode #(
    parameter int IDX_W  = 4,
    parameter int SLOTS  = 8
) (
    input  logic             active,
    input  logic             sel,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output logic [SLOTS-1:0] wr_hit,
    output logic [SLOTS-1:0] rd_hit
);

    logic acc_w;
    logic acc_r;

    assign acc_w = active & sel & we;
    assign acc_r = active & sel & ~we;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign wr_hit[g] = acc_w & (idx == IDX_W'(g));
            assign rd_hit[g] = acc_r & (idx == IDX_W'(g + SLOTS));
        end
    endgenerate

endmodule

// File: rtl/flp_enh_pram.sv
module flp_enh_pram #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_clr) begin
            ptr_q <= '0;
        end else if (wr_en || rd_en) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // Contents are deliberately left out of reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[ptr_q] <= wdata;
        end
    end

    assign rdata = mem[ptr_q];

endmodule

// File: rtl/flp_enh_ctrl.sv
module flp_enh_ctrl
    import flp_enh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic              clr_wr,
    input  logic              set_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic              active,
    output logic              release_pulse
);

    localparam logic [DATA_W-1:0] ACT_MASK = DATA_W'(1) << ACT_BIT;

    pers_state_e       state_q;
    pers_state_e       state_d;
    logic [DATA_W-1:0] mode_cleared;

    assign mode_cleared = mode_q & ~wdata;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEGACY:   if (enter_req) state_d = ST_ENHANCED;
            ST_ENHANCED: if (clr_wr && !mode_cleared[ACT_BIT]) state_d = ST_RELEASE;
            ST_RELEASE:  state_d = ST_LEGACY;
            default:     state_d = ST_LEGACY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LEGACY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        active        = (state_q == ST_ENHANCED);
        release_pulse = (state_q == ST_RELEASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (state_q == ST_LEGACY && enter_req) begin
            mode_q <= mode_q | ACT_MASK;
        end else if (clr_wr) begin
            mode_q <= mode_cleared;
        end else if (set_wr) begin
            mode_q <= mode_q | wdata;
        end
    end

endmodule

// File: rtl/flp_enh_regbank.sv
module flp_enh_regbank
    import flp_enh_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int REG_SHIFT  = 9,
    parameter int DATA_W     = 8,
    parameter int PRAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_enhanced,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              enhanced_active,
    output logic              legacy_latch_clr,
    output logic [DATA_W-1:0] mode_out
);

    localparam int IDX_W = ADDR_W - REG_SHIFT;
    localparam int SLOTS = 1 << (IDX_W - 1);

    logic [IDX_W-1:0]  reg_idx;
    logic [SLOTS-1:0]  wr_hit;
    logic [SLOTS-1:0]  rd_hit;
    logic [DATA_W-1:0] phase_q;
    logic [DATA_W-1:0] pram_rdata;
    logic              unused_addr_low;

    assign reg_idx         = bus_addr[ADDR_W-1:REG_SHIFT];
    assign unused_addr_low = ^bus_addr[REG_SHIFT-1:0];

    flp_enh_decode #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_dec (
        .active (enhanced_active),
        .sel    (bus_sel),
        .we     (bus_we),
        .idx    (reg_idx),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    flp_enh_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_req     (enter_enhanced),
        .clr_wr        (wr_hit[WS_CLR]),
        .set_wr        (wr_hit[WS_SET]),
        .wdata         (bus_wdata),
        .mode_q        (mode_out),
        .active        (enhanced_active),
        .release_pulse (legacy_latch_clr)
    );

    flp_enh_pram #(.DEPTH(PRAM_DEPTH), .DATA_W(DATA_W)) u_pram (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_clr (wr_hit[WS_CLR]),
        .wr_en   (wr_hit[WS_PARAM]),
        .rd_en   (rd_hit[RS_PARAM]),
        .wdata   (bus_wdata),
        .rdata   (pram_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (wr_hit[WS_PHASE]) begin
            phase_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit[RS_PARAM]) begin
            bus_rdata = pram_rdata;
        end else if (rd_hit[RS_PHASE]) begin
            bus_rdata = phase_q;
        end else if (rd_hit[RS_STATUS]) begin
            bus_rdata = DATA_W'(enhanced_active) << ACT_BIT;
        end else if (rd_hit[RS_HSHAKE]) begin
            bus_rdata = (phase_q == DATA_W'(NO_DRIVE_PHASE)) ? DATA_W'(SENSE_VALUE) : '0;
        end
    end

endmodule

// File: rtl/flp_enh_regbank_chk.sv
module flp_enh_regbank_chk #(
    parameter int ADDR_W    = 13,
    parameter int REG_SHIFT = 9,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_enhanced,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              enhanced_active,
    input logic              legacy_latch_clr,
    input logic [DATA_W-1:0] mode_out
);

    localparam int IDX_W = ADDR_W - REG_SHIFT;

    logic [IDX_W-1:0] idx;
    logic             unused_chk_low;

    assign idx            = bus_addr[ADDR_W-1:REG_SHIFT];
    assign unused_chk_low = ^bus_addr[REG_SHIFT-1:0];

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_latch_clr |=> !legacy_latch_clr);

    a_r7_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enhanced_active) |-> legacy_latch_clr);

    a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!enhanced_active && !legacy_latch_clr && enter_enhanced) |=> (enhanced_active && mode_out[6]));

    a_r3_bit6_held: assert property (@(posedge clk) disable iff (!rst_n)
        enhanced_active |-> mode_out[6]);

    a_r2_legacy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enhanced_active |-> (bus_rdata == '0));

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_we) |-> (bus_rdata == '0));

    a_r5_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (enhanced_active && bus_sel && bus_we && idx == IDX_W'(7))
        |=> ((mode_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
        (enhanced_active && bus_sel && !bus_we && idx == IDX_W'(14)) |-> (bus_rdata == 8'h40));

    a_r9_handshake_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (enhanced_active && bus_sel && !bus_we && idx == IDX_W'(15))
        |-> (bus_rdata == 8'h00 || bus_rdata == 8'h08));

endmodule

bind flp_enh_regbank flp_enh_regbank_chk #(
    .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT), .DATA_W(DATA_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .enter_enhanced   (enter_enhanced),
    .bus_sel          (bus_sel),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .enhanced_active  (enhanced_active),
    .legacy_latch_clr (legacy_latch_clr),
    .mode_out         (mode_out)
);

// File: tb/flp_enh_regbank_test.sv
`timescale 1ns/1ps
module flp_enh_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_enhanced = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        enhanced_active;
    logic        legacy_latch_clr;
    logic [7:0]  mode_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flp_enh_regbank uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .enter_enhanced   (enter_enhanced),
        .bus_sel          (bus_sel),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .enhanced_active  (enhanced_active),
        .legacy_latch_clr (legacy_latch_clr),
        .mode_out         (mode_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Low address bits carry junk so the index decode is exercised (R4).
    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = {idx[3:0], 9'h0AB}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        #0.5;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_addr = {idx[3:0], 9'h155};
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #0.5;
    endtask

    task automatic enter();
        @(negedge clk);
        enter_enhanced = 1'b1;
        @(negedge clk);
        enter_enhanced = 1'b0;
        #0.5;
    endtask

    function automatic logic [7:0] pv(input int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic t_reset();
        #1;
        chk("R1 active", {7'd0, enhanced_active}, 8'h00);
        chk("R1 clr", {7'd0, legacy_latch_clr}, 8'h00);
        chk("R1 mode", mode_out, 8'h00);
        chk("R12 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_legacy_ignored();
        logic [7:0] d;
        wr(4, 8'h55);
        wr(7, 8'h0F);
        rd(12, d);
        chk("R2 legacy read", d, 8'h00);
        chk("R2 legacy mode", mode_out, 8'h00);
        chk("R2 legacy active", {7'd0, enhanced_active}, 8'h00);
    endtask

    task automatic t_enter();
        logic [7:0] d;
        enter();
        chk("R3 active", {7'd0, enhanced_active}, 8'h01);
        chk("R3 mode bit6", mode_out, 8'h40);
        rd(12, d);
        chk("R1/R2 phase after entry", d, 8'h00);
    endtask

    task automatic t_phase();
        logic [7:0] d;
        wr(4, 8'hA5);
        rd(12, d);
        chk("R4 phase A5", d, 8'hA5);
        wr(4, 8'h12);
        rd(12, d);
        chk("R4 phase 12", d, 8'h12);
    endtask

    task automatic t_handshake();
        logic [7:0] d;
        wr(4, 8'h77);
        rd(15, d);
        chk("R9 no drive", d, 8'h08);
        wr(4, 8'h07);
        rd(15, d);
        chk("R9 phase 07", d, 8'h00);
        wr(4, 8'h76);
        rd(15, d);
        chk("R9 phase 76", d, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        rd(14, d);
        chk("R10 status", d, 8'h40);
    endtask

    task automatic t_mode();
        wr(7, 8'h21);
        chk("R5 set", mode_out, 8'h61);
        wr(6, 8'h01);
        chk("R6 clear", mode_out, 8'h60);
        chk("R6 stays enhanced", {7'd0, enhanced_active}, 8'h01);
    endtask

    task automatic t_pram();
        logic [7:0] d;
        wr(6, 8'h00);
        for (int i = 0; i < 16; i++) wr(3, pv(i));
        wr(3, 8'hEE);   // wraps onto entry 0
        wr(6, 8'h00);
        for (int i = 0; i < 16; i++) begin
            rd(11, d);
            chk("R8 readback", d, (i == 0) ? 8'hEE : pv(i));
        end
        rd(11, d);
        chk("R8 read wrap", d, 8'hEE);
        wr(6, 8'h00);
        wr(3, 8'h11);
        rd(11, d);
        chk("R8 shared pointer", d, pv(1));
        rd(11, d);
        chk("R8 next entry", d, pv(2));
        wr(6, 8'h00);
        rd(11, d);
        chk("R6 pointer reset", d, 8'h11);
        chk("R6 zero clear keeps mode", mode_out, 8'h60);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        wr(6, 8'h00);
        wr(0, 8'hC3); wr(1, 8'hC4); wr(2, 8'hC5); wr(5, 8'hC6);
        wr(12, 8'h33); wr(11, 8'h44);
        for (int k = 0; k < 4; k++) begin
            int ix;
            ix = (k == 3) ? 13 : 8 + k;
            rd(ix, d);
            chk("R11 unimplemented read", d, 8'h00);
        end
        rd(3, d);
        chk("R11 read of write index", d, 8'h00);
        rd(12, d);
        chk("R11 phase untouched", d, 8'h76);
        chk("R11 mode untouched", mode_out, 8'h60);
        rd(11, d);
        chk("R11 pointer untouched", d, 8'h11);
    endtask

    task automatic t_exit();
        logic [7:0] d;
        wr(6, 8'h40);
        chk("R7 active drops", {7'd0, enhanced_active}, 8'h00);
        chk("R7 clr pulse", {7'd0, legacy_latch_clr}, 8'h01);
        chk("R7 mode after", mode_out, 8'h20);
        @(negedge clk); #0.5;
        chk("R7 pulse ends", {7'd0, legacy_latch_clr}, 8'h00);
        wr(4, 8'h99);
        rd(12, d);
        chk("R2 legacy after exit", d, 8'h00);
        enter();
        chk("R3 reentry mode", mode_out, 8'h60);
        rd(12, d);
        chk("R2 phase kept", d, 8'h76);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_legacy_ignored();
        t_enter();
        t_phase();
        t_handshake();
        t_status();
        t_mode();
        t_pram();
        t_ignored();
        t_exit();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule